// File: doc/BRIEF.md
# Byte Store Sequencer with Set-Only Start Bits

This unit sits between a host register bus and a small on-chip byte store of 256 entries of 8 bits. The host sees three byte-wide locations: a control byte, an address byte and a data byte. It starts a one-cycle read, or a self-timed write of programmable length, by setting a bit in the control byte. Hardware clears that bit when the operation finishes, and software can never clear it.

Writes are gated by an enable bit. A write that is attempted without that enable is refused and recorded in an error flag. A warm reset that lands in the middle of a write also sets the error flag. Two select bits are kept and read back as plain state. They block reads, and they keep a timed cycle from touching the store. A row-erase request bit only rides along with a timed cycle and drops when that cycle ends.

Top module: `nvb_ctrl`

## Requirements
- R1: After a power-on reset (`rst_n` low at a clock edge), the control, address and data bytes all read 0x00 and `busy` is 0.
- R2: The control byte fields are: bit7 memory select, bit6 config select, bit5 always reads 0, bit4 erase request, bit3 error flag, bit2 write enable, bit1 write start, bit0 read start. Bus select values are 0 for control, 1 for address, 2 for data and 3 for none, which reads 0x00. Writing 0 to a start bit never cancels an operation that has already begun.
- R3: Writing a control byte with bit0=1 makes bit0 read 1 for exactly one cycle. At the following edge the store byte at the current address is loaded into the data register and bit0 clears.
- R4: A read start is ignored, leaving bit0 at 0 and the data register unchanged, when the same control write sets bit7 or bit6.
- R5: A control write with bit1=1 and bit2=1 starts a write cycle. `busy` and bit1 stay 1 for exactly WR_CYCLES cycles and then clear together. The cycle ends with the data register stored at the address and the error flag cleared.
- R6: A control write with bit1=1 and bit2=0 sets the error flag. Bit1 stays 0, no cycle starts and the store is unchanged.
- R7: A write cycle started with bit4, bit7 or bit6 set runs its full length but leaves the store unchanged. Bit4 reads 0 once the cycle ends.
- R8: While `busy` is 1, bus writes to the control, address and data locations are ignored.
- R9: A low `warm_rst_n` during a write cycle aborts it. `busy` drops, the error flag sets, the store byte is unchanged, bit7 and bit6 keep their values, and bits 4, 2, 1 and 0 clear.
- R10: When idle, software can write the error flag, which is how a recorded error is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| warm_rst_n | input | 1 | Synchronous active-low warm reset that aborts a write |
| bus_wr | input | 1 | Host write strobe for one cycle |
| bus_sel | input | 2 | Location select: 0 control, 1 address, 2 data |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Combinational readback of the selected location |
| busy | output | 1 | High for the whole self-timed write cycle |

## Verification
Directed sequences cover each control-byte case: a plain write, a write with the erase request set, a write with a select bit set, a write without enable, reads with a select bit set, and warm resets in the middle of a cycle with and without a select bit set. Together these separate the path that commits to the store from every path that must leave it untouched. Seeded random address and data pairs are then written and read back against a bench model of the store. Each write cycle's length is also measured. This exposes address decoding faults, data corruption and timer length errors that a single fixed pattern would not show.

// File: rtl/nvb_pkg.sv
// Shared field positions and bus location codes for the byte store sequencer.
// Assumes an 8-bit host bus and an 8-bit control byte.
package nvb_pkg;
    localparam int BUS_W      = 8;
    localparam int CTRL_RD    = 0;
    localparam int CTRL_WR    = 1;
    localparam int CTRL_WEN   = 2;
    localparam int CTRL_ERR   = 3;
    localparam int CTRL_ERASE = 4;
    localparam int CTRL_CFG   = 6;
    localparam int CTRL_MEM   = 7;

    typedef enum logic [1:0] {
        LOC_CTRL = 2'd0,
        LOC_ADDR = 2'd1,
        LOC_DATA = 2'd2,
        LOC_NONE = 2'd3
    } bus_loc_e;
endpackage

// File: rtl/nvb_store.sv
// Byte array with one synchronous write port and a combinational read port.
// Assumes no reset of contents; the caller only commits whole bytes.
module nvb_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit one byte on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/nvb_timer.sv
// Countdown timer that times one write cycle of CYC clocks.
// Assumes start is never asserted while active; either reset aborts a cycle.
module nvb_timer #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic warm_rst_n,
    input  logic start,
    output logic active,
    output logic done
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

    logic [CW-1:0] cnt;

    // Load on start, count down while active, stop at zero or on reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !warm_rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= CW'(CYC - 1);
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign done = active && (cnt == '0);

    // A finished cycle drops activity at the next edge.
    assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !active);
endmodule

// File: rtl/nvb_csr.sv
// Control byte: set-only start bits, write enable gating, error recording.
// Assumes wr_active and wr_done come from the timer that start_wr launches.
module nvb_csr
    import nvb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_rst_n,
    input  logic             ctrl_we,
    input  logic [BUS_W-1:0] wdata,
    input  logic             wr_active,
    input  logic             wr_done,
    output logic             start_wr,
    output logic             rd_go,
    output logic [BUS_W-1:0] ctrl_q
);
    logic mem_sel, cfg_sel, erase_en, err, wr_en, wr_go;
    logic accept;
    wire  unused_bit5 = wdata[5];

    assign accept   = ctrl_we && !wr_active;
    assign start_wr = warm_rst_n && accept && wdata[CTRL_WR] && wdata[CTRL_WEN];

    // Field updates in priority order: power-on, warm abort, completion, host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_sel  <= 1'b0;
            cfg_sel  <= 1'b0;
            erase_en <= 1'b0;
            err      <= 1'b0;
            wr_en    <= 1'b0;
            wr_go    <= 1'b0;
            rd_go    <= 1'b0;
        end else if (!warm_rst_n) begin
            if (wr_active) err <= 1'b1;
            erase_en <= 1'b0;
            wr_en    <= 1'b0;
            wr_go    <= 1'b0;
            rd_go    <= 1'b0;
        end else begin
            if (rd_go) rd_go <= 1'b0;
            if (wr_done) begin
                wr_go    <= 1'b0;
                erase_en <= 1'b0;
                err      <= 1'b0;
            end
            if (accept) begin
                mem_sel  <= wdata[CTRL_MEM];
                cfg_sel  <= wdata[CTRL_CFG];
                erase_en <= wdata[CTRL_ERASE];
                err      <= wdata[CTRL_ERR];
                wr_en    <= wdata[CTRL_WEN];
                if (wdata[CTRL_WR]) begin
                    if (wdata[CTRL_WEN]) wr_go <= 1'b1;
                    else                 err   <= 1'b1;
                end else if (wdata[CTRL_RD] && !wdata[CTRL_MEM] && !wdata[CTRL_CFG]) begin
                    rd_go <= 1'b1;
                end
            end
        end
    end

    // Pack the fields into the readable byte.
    always_comb begin
        ctrl_q             = '0;
        ctrl_q[CTRL_MEM]   = mem_sel;
        ctrl_q[CTRL_CFG]   = cfg_sel;
        ctrl_q[CTRL_ERASE] = erase_en;
        ctrl_q[CTRL_ERR]   = err;
        ctrl_q[CTRL_WEN]   = wr_en;
        ctrl_q[CTRL_WR]    = wr_go;
        ctrl_q[CTRL_RD]    = rd_go;
    end

    // A read start lasts one cycle unless the host re-arms it.
    assert_rd_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !ctrl_we) |=> !rd_go);
    // A read never begins with a select bit set.
    assert_rd_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_go) |-> (!mem_sel && !cfg_sel));
    // A write never begins without the enable.
    assert_wr_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_go) |-> wr_en);
endmodule

// File: rtl/nvb_ctrl.sv
// Top: host-visible address/data registers, readback mux, and the link
// between control byte, write timer and byte store.
// Assumes ADDR_W <= 8 so the address fits the host bus.
module nvb_ctrl
    import nvb_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int WR_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_sel,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             busy
);
    bus_loc_e          loc;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  data_q;
    logic [BUS_W-1:0]  ctrl_q;
    logic [BUS_W-1:0]  store_rdata;
    logic              start_wr, rd_go, wr_done, commit;

    assign loc = bus_loc_e'(bus_sel);

    nvb_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .warm_rst_n(warm_rst_n),
        .ctrl_we   (bus_wr && (loc == LOC_CTRL)),
        .wdata     (bus_wdata),
        .wr_active (busy),
        .wr_done   (wr_done),
        .start_wr  (start_wr),
        .rd_go     (rd_go),
        .ctrl_q    (ctrl_q)
    );

    nvb_timer #(.CYC(WR_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .warm_rst_n(warm_rst_n),
        .start     (start_wr),
        .active    (busy),
        .done      (wr_done)
    );

    assign commit = wr_done && warm_rst_n && !ctrl_q[CTRL_ERASE]
                    && !ctrl_q[CTRL_MEM] && !ctrl_q[CTRL_CFG];

    nvb_store #(.ADDR_W(ADDR_W), .DATA_W(BUS_W)) u_store (
        .clk  (clk),
        .we   (commit),
        .addr (addr_q),
        .wdata(data_q),
        .rdata(store_rdata)
    );

    // Host address/data registers; frozen while a write cycle runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (rd_go && warm_rst_n)
                data_q <= store_rdata;
            else if (bus_wr && loc == LOC_DATA && !busy)
                data_q <= bus_wdata;
            if (bus_wr && loc == LOC_ADDR && !busy)
                addr_q <= bus_wdata[ADDR_W-1:0];
        end
    end

    // Readback mux of the selected location.
    always_comb begin
        case (loc)
            LOC_CTRL: bus_rdata = ctrl_q;
            LOC_ADDR: bus_rdata = BUS_W'(addr_q);
            LOC_DATA: bus_rdata = data_q;
            default:  bus_rdata = '0;
        endcase
    end

    // The write start bit mirrors the timer for the whole cycle.
    assert_wr_tracks_timer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CTRL_WR] == busy);
    // Address register holds while busy.
    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && loc == LOC_ADDR) |=> $stable(addr_q));
    // Warm reset mid-cycle records an error and ends the cycle.
    assert_warm_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!warm_rst_n && busy) |=> (ctrl_q[CTRL_ERR] && !busy));
endmodule

// File: tb/nvb_ctrl_bench.sv
module nvb_ctrl_bench;
    localparam int CYC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       warm_rst_n = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_sel = 2'd3;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;
    logic [7:0] model [256];
    bit         known [256];

    nvb_ctrl #(.ADDR_W(8), .WR_CYCLES(CYC)) u_nvb_ctrl (
        .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n), .bus_wr(bus_wr),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] cbyte(bit m, bit c, bit e, bit er, bit en, bit w, bit r);
        return {m, c, 1'b0, e, er, en, w, r};
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bwrite(logic [1:0] s, logic [7:0] v);
        @(negedge clk);
        bus_sel = s; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(logic [1:0] s, output logic [7:0] v);
        bus_sel = s;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic store_read(logic [7:0] a, output logic [7:0] v);
        bwrite(2'd1, a);
        bwrite(2'd0, 8'h01);
        @(negedge clk);
        bread(2'd2, v);
    endtask

    task automatic store_write(logic [7:0] a, logic [7:0] d, logic [7:0] c, output int n);
        bwrite(2'd1, a);
        bwrite(2'd2, d);
        bwrite(2'd0, c);
        wait_idle(n);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: got hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        int n;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bread(2'd0, v); check("R1 ctrl", v, 8'h00);
        bread(2'd1, v); check("R1 addr", v, 8'h00);
        bread(2'd2, v); check("R1 data", v, 8'h00);
        check("R1 busy", {7'd0, busy}, 8'h00);

        // R5 plain write: length, bit1 during cycle, completion state
        bwrite(2'd1, 8'h10);
        bwrite(2'd2, 8'hA5);
        bwrite(2'd0, 8'h06);
        bread(2'd0, v); check("R5 ctrl busy", v, cbyte(0,0,0,0,1,1,0));
        wait_idle(n);
        check("R5 length", 8'(n), 8'(CYC));
        bread(2'd0, v); check("R5 ctrl done", v, cbyte(0,0,0,0,1,0,0));
        model[8'h10] = 8'hA5; known[8'h10] = 1'b1;

        // R3 read: one-cycle start bit, data loaded
        bwrite(2'd2, 8'h00);
        bwrite(2'd0, 8'h05);
        bread(2'd0, v); check("R3 rd pending", v, cbyte(0,0,0,0,1,0,1));
        @(negedge clk);
        bread(2'd0, v); check("R3 rd cleared", v, cbyte(0,0,0,0,1,0,0));
        bread(2'd2, v); check("R3 data", v, 8'hA5);

        // R2 bit5 reads zero; writing 0 right after a read start does not cancel it
        bwrite(2'd0, 8'h20);
        bread(2'd0, v); check("R2 bit5", v, 8'h00);
        bwrite(2'd2, 8'h00);
        @(negedge clk);
        bus_sel = 2'd0; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk);
        bus_wdata = 8'h00;
        @(negedge clk);
        bus_wr = 1'b0;
        bread(2'd2, v); check("R2 zero no cancel", v, 8'hA5);
        bread(2'd3, v); check("R2 none loc", v, 8'h00);

        // R4 read blocked by selects
        bwrite(2'd2, 8'h33);
        bwrite(2'd0, 8'h81);
        bread(2'd0, v); check("R4 mem sel", v, cbyte(1,0,0,0,0,0,0));
        @(negedge clk);
        bread(2'd2, v); check("R4 data kept mem", v, 8'h33);
        bwrite(2'd0, 8'h41);
        bread(2'd0, v); check("R4 cfg sel", v, cbyte(0,1,0,0,0,0,0));
        @(negedge clk);
        bread(2'd2, v); check("R4 data kept cfg", v, 8'h33);

        // R6 write without enable
        bwrite(2'd0, 8'h02);
        bread(2'd0, v); check("R6 err set", v, cbyte(0,0,0,1,0,0,0));
        check("R6 not busy", {7'd0, busy}, 8'h00);
        @(negedge clk);
        check("R6 still idle", {7'd0, busy}, 8'h00);
        // R10 software clears error
        bwrite(2'd0, 8'h00);
        bread(2'd0, v); check("R10 err cleared", v, 8'h00);
        store_read(8'h10, v); check("R6 store kept", v, 8'hA5);

        // R7 erase request and select bits leave store alone
        store_write(8'h10, 8'h5A, 8'h16, n);
        check("R7 erase length", 8'(n), 8'(CYC));
        bread(2'd0, v); check("R7 erase bit cleared", v, cbyte(0,0,0,0,1,0,0));
        store_read(8'h10, v); check("R7 erase store kept", v, 8'hA5);
        store_write(8'h10, 8'h5A, 8'h86, n);
        bread(2'd0, v); check("R7 mem sel done", v, cbyte(1,0,0,0,1,0,0));
        store_read(8'h10, v); check("R7 sel store kept", v, 8'hA5);

        // R8 writes ignored while busy
        bwrite(2'd1, 8'h20);
        bwrite(2'd2, 8'h11);
        bwrite(2'd0, 8'h06);
        bwrite(2'd1, 8'h21);
        bwrite(2'd2, 8'h99);
        bwrite(2'd0, 8'h80);
        bread(2'd1, v); check("R8 addr frozen", v, 8'h20);
        bread(2'd2, v); check("R8 data frozen", v, 8'h11);
        bread(2'd0, v); check("R8 ctrl frozen", v, cbyte(0,0,0,0,1,1,0));
        wait_idle(n);
        model[8'h20] = 8'h11; known[8'h20] = 1'b1;
        store_read(8'h20, v); check("R8 stored", v, 8'h11);
        store_read(8'h21, v);
        if (known[8'h21]) check("R8 other addr", v, model[8'h21]);

        // R9 warm reset aborts mid-cycle
        bwrite(2'd1, 8'h10);
        bwrite(2'd2, 8'hEE);
        bwrite(2'd0, 8'h06);
        repeat (4) @(negedge clk);
        warm_rst_n = 1'b0;
        @(negedge clk);
        warm_rst_n = 1'b1;
        check("R9 busy dropped", {7'd0, busy}, 8'h00);
        bread(2'd0, v); check("R9 ctrl", v, cbyte(0,0,0,1,0,0,0));
        store_read(8'h10, v); check("R9 store kept", v, 8'hA5);
        bwrite(2'd0, 8'h46);
        repeat (3) @(negedge clk);
        warm_rst_n = 1'b0;
        @(negedge clk);
        warm_rst_n = 1'b1;
        bread(2'd0, v); check("R9 select kept", v, cbyte(0,1,0,1,0,0,0));
        bwrite(2'd0, 8'h00);

        // R5 R3 random write/readback
        for (int i = 0; i < 40; i++) begin
            logic [7:0] a, d;
            a = 8'($urandom);
            d = 8'($urandom);
            store_write(a, d, 8'h06, n);
            check("R5 random length", 8'(n), 8'(CYC));
            model[a] = d; known[a] = 1'b1;
            if (i % 4 == 3) begin
                for (int j = 0; j < 256; j++) begin
                    if (known[j] && ($urandom % 8 == 0)) begin
                        store_read(8'(j), v);
                        check("R3 random readback", v, model[j]);
                    end
                end
            end
        end
        store_read(8'h10, v);
        check("R3 final readback", v, model[8'h10]);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule